// File: doc/BRIEF.md
# SPI Pause Controller

This block sits between the pins of an SPI slave and its shift logic. It gives the bus master a way to pause a transfer in mid-stream without deselecting the slave. The four pins are the active-low select, the serial clock, the active-low pause request and serial data in. All four are brought into the system clock domain through a parameterized synchronizer chain.

A falling edge on the pause pin while the slave is selected arms a pause. The pause takes effect only while the serial clock is low. If the clock is high at that moment, the pause waits until the clock next goes low. Leaving the pause follows the same rule: the pause pin must be high and the serial clock low.

While paused, the core sees a serial clock held low and a frozen data-in bit. The serial output enable is also forced off. The core keeps its bit counter and shift contents, so after the pause it continues at the same bit. Its own output enable request then applies again, which returns SO to whatever state it had before the pause.

If the select pin goes high during a pause, the block drives a core reset pulse of `RST_LEN` system clocks and clears the pause. The next select cycle then starts clean.

Top module: `spi_pause_ctrl`

## Requirements
- R1: After reset, `hold_active` is 0 and `core_rst` is 0. With `cs_n_pin` high, `so_oe` is 0.
- R2: A falling edge of `hold_n_pin` while `cs_n_pin` is low and `sclk_pin` is low sets `hold_active` within `SYNC_STAGES`+2 system clocks.
- R3: A falling edge of `hold_n_pin` while `sclk_pin` is high does not set `hold_active` while `sclk_pin` stays high. `hold_active` is set once `sclk_pin` goes low, provided `hold_n_pin` is still low.
- R4: A falling edge of `hold_n_pin` while `cs_n_pin` is high never starts a pause, even after `cs_n_pin` later goes low.
- R5: In a pause, `hold_n_pin` going high while `sclk_pin` is low clears `hold_active`.
- R6: In a pause, `hold_n_pin` going high while `sclk_pin` is high leaves `hold_active` at 1 until `sclk_pin` goes low.
- R7: While `hold_active` is 1, `core_sclk` is 0 and `core_si` holds its value, whatever the pins do. Entry into a pause only happens from a cycle in which `core_sclk` was 0.
- R8: While `hold_active` is 1, `so_oe` is 0. After exit, `so_oe` again equals `core_so_oe` (1 or 0) while selected.
- R9: `cs_n_pin` going high during a pause drives `core_rst` to 1 for exactly `RST_LEN` system clocks and clears `hold_active` no later than the rising edge of `core_rst`.
- R10: Outside a pause, `core_sclk`, `core_si` and `core_cs_n` follow the pins after `SYNC_STAGES` clocks. `so_oe` equals `core_so_oe` while selected and is 0 while deselected. `so_data` always equals `core_so`.
- R11: An armed but not yet active pause is dropped if `hold_n_pin` returns high before `sclk_pin` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_pin | input | 1 | Slave select pin, active low |
| sclk_pin | input | 1 | Serial clock pin |
| hold_n_pin | input | 1 | Pause request pin, active low |
| si_pin | input | 1 | Serial data in pin |
| core_so | input | 1 | Serial data out from the core |
| core_so_oe | input | 1 | Output enable request from the core |
| core_cs_n | output | 1 | Synchronized select toward the core |
| core_sclk | output | 1 | Gated serial clock toward the core |
| core_si | output | 1 | Gated serial data in toward the core |
| core_rst | output | 1 | Core reset pulse, active high |
| hold_active | output | 1 | Pause in effect |
| so_data | output | 1 | Data for the SO pad |
| so_oe | output | 1 | Enable for the SO pad |

## Verification
The bench builds the block with `SYNC_STAGES` = 2 and `RST_LEN` = 3. Two stages give a short, known pin-to-state latency, so a fixed settle wait after each pin change covers every register on the path. A three-cycle reset pulse is long enough that the bench can count it cycle by cycle and tell an exact width apart from an off-by-one. With these values, every deferral path can be reached in a few hundred clocks: entry waiting for the clock to fall, exit waiting for the clock to fall, and an armed pause being cancelled.

// File: rtl/spi_pause_pkg.sv
package spi_pause_pkg;
  typedef enum logic [1:0] {
    PZ_PASS   = 2'd0,
    PZ_ARMED  = 2'd1,
    PZ_PAUSED = 2'd2
  } pause_state_e;

  localparam int PIN_W   = 4;
  localparam int IDX_CS  = 0;
  localparam int IDX_CLK = 1;
  localparam int IDX_HLD = 2;
  localparam int IDX_SI  = 3;
  localparam logic [PIN_W-1:0] PIN_IDLE = 4'b0101; // si=0, hold_n=1, sclk=0, cs_n=1
endpackage

// File: rtl/spi_pause_sync.sv
module spi_pause_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] INIT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= INIT;
        else        stage_q[s] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= INIT;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/spi_pause_fsm.sv
module spi_pause_fsm
  import spi_pause_pkg::*;
#(
  parameter int RST_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_s,
  input  logic sclk_s,
  input  logic hold_n_s,
  output logic paused,
  output logic core_rst
);
  localparam int CNT_W = $clog2(RST_LEN + 1);

  pause_state_e state_q, state_d;
  logic         hold_n_d;
  logic         hold_fall;
  logic         drop_evt;
  logic [CNT_W-1:0] rst_cnt_q;

  assign hold_fall = hold_n_d & ~hold_n_s;
  assign drop_evt  = (state_q == PZ_PAUSED) & cs_n_s;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PZ_PASS: begin
        if (!cs_n_s && hold_fall)
          state_d = sclk_s ? PZ_ARMED : PZ_PAUSED;
      end
      PZ_ARMED: begin
        if (cs_n_s || hold_n_s) state_d = PZ_PASS;
        else if (!sclk_s)       state_d = PZ_PAUSED;
      end
      PZ_PAUSED: begin
        if (cs_n_s)                   state_d = PZ_PASS;
        else if (hold_n_s && !sclk_s) state_d = PZ_PASS;
      end
      default: state_d = PZ_PASS;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= PZ_PASS;
      hold_n_d <= 1'b1;
    end else begin
      state_q  <= state_d;
      hold_n_d <= hold_n_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                rst_cnt_q <= '0;
    else if (drop_evt)         rst_cnt_q <= CNT_W'(RST_LEN);
    else if (rst_cnt_q != '0)  rst_cnt_q <= rst_cnt_q - 1'b1;
  end

  assign paused   = (state_q == PZ_PAUSED);
  assign core_rst = (rst_cnt_q != '0);
endmodule

// File: rtl/spi_pause_gate.sv
module spi_pause_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic paused,
  input  logic cs_n_s,
  input  logic sclk_s,
  input  logic si_s,
  input  logic core_so,
  input  logic core_so_oe,
  output logic core_sclk,
  output logic core_si,
  output logic so_data,
  output logic so_oe
);
  logic si_held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       si_held_q <= 1'b0;
    else if (!paused) si_held_q <= si_s;
  end

  assign core_sclk = paused ? 1'b0 : sclk_s;
  assign core_si   = paused ? si_held_q : si_s;
  assign so_data   = core_so;
  assign so_oe     = core_so_oe & ~paused & ~cs_n_s;
endmodule

// File: rtl/spi_pause_ctrl.sv
module spi_pause_ctrl
  import spi_pause_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_pin,
  input  logic sclk_pin,
  input  logic hold_n_pin,
  input  logic si_pin,
  input  logic core_so,
  input  logic core_so_oe,
  output logic core_cs_n,
  output logic core_sclk,
  output logic core_si,
  output logic core_rst,
  output logic hold_active,
  output logic so_data,
  output logic so_oe
);
  logic [PIN_W-1:0] pins_raw, pins_s;
  logic             paused;

  assign pins_raw[IDX_CS]  = cs_n_pin;
  assign pins_raw[IDX_CLK] = sclk_pin;
  assign pins_raw[IDX_HLD] = hold_n_pin;
  assign pins_raw[IDX_SI]  = si_pin;

  spi_pause_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES), .INIT(PIN_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pins_raw), .dout(pins_s)
  );

  spi_pause_fsm #(.RST_LEN(RST_LEN)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .cs_n_s(pins_s[IDX_CS]), .sclk_s(pins_s[IDX_CLK]), .hold_n_s(pins_s[IDX_HLD]),
    .paused(paused), .core_rst(core_rst)
  );

  spi_pause_gate u_gate (
    .clk(clk), .rst_n(rst_n), .paused(paused),
    .cs_n_s(pins_s[IDX_CS]), .sclk_s(pins_s[IDX_CLK]), .si_s(pins_s[IDX_SI]),
    .core_so(core_so), .core_so_oe(core_so_oe),
    .core_sclk(core_sclk), .core_si(core_si), .so_data(so_data), .so_oe(so_oe)
  );

  assign core_cs_n   = pins_s[IDX_CS];
  assign hold_active = paused;
endmodule

// File: rtl/spi_pause_chk.sv
module spi_pause_chk (
  input logic clk,
  input logic rst_n,
  input logic hold_active,
  input logic core_sclk,
  input logic core_si,
  input logic core_rst,
  input logic so_oe,
  input logic so_data,
  input logic core_so
);
  AST_PAUSE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    hold_active |-> !core_sclk); // R7
  AST_PAUSE_SI_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    hold_active && $past(hold_active) |-> $stable(core_si)); // R7
  AST_ENTER_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_active) |-> !$past(core_sclk)); // R7
  AST_PAUSE_SO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    hold_active |-> !so_oe); // R8
  AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_rst) |-> !hold_active); // R9
  AST_SO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    so_data == core_so); // R10
endmodule

bind spi_pause_ctrl spi_pause_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hold_active(hold_active), .core_sclk(core_sclk),
  .core_si(core_si), .core_rst(core_rst), .so_oe(so_oe), .so_data(so_data),
  .core_so(core_so)
);

// File: tb/tb_spi_pause_ctrl.sv
module tb_spi_pause_ctrl;
  localparam int SYNC_STAGES = 2;
  localparam int RST_LEN = 3;
  localparam int SETTLE = SYNC_STAGES + 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n_pin = 1'b1, sclk_pin = 1'b0, hold_n_pin = 1'b1, si_pin = 1'b0;
  logic core_so = 1'b0, core_so_oe = 1'b1;
  logic core_cs_n, core_sclk, core_si, core_rst, hold_active, so_data, so_oe;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  spi_pause_ctrl #(.SYNC_STAGES(SYNC_STAGES), .RST_LEN(RST_LEN)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n_pin(cs_n_pin), .sclk_pin(sclk_pin),
    .hold_n_pin(hold_n_pin), .si_pin(si_pin), .core_so(core_so), .core_so_oe(core_so_oe),
    .core_cs_n(core_cs_n), .core_sclk(core_sclk), .core_si(core_si), .core_rst(core_rst),
    .hold_active(hold_active), .so_data(so_data), .so_oe(so_oe)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic settle(input int n = SETTLE);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1", "hold_active", hold_active, 1'b0);
    chk("R1", "core_rst", core_rst, 1'b0);
    chk("R1", "so_oe", so_oe, 1'b0);
  endtask

  task automatic t_pass;
    cs_n_pin = 1'b0; core_so_oe = 1'b1; settle();
    chk("R10", "so_oe selected", so_oe, 1'b1);
    chk("R10", "core_cs_n", core_cs_n, 1'b0);
    sclk_pin = 1'b1; si_pin = 1'b1; settle();
    chk("R10", "core_sclk follows", core_sclk, 1'b1);
    chk("R10", "core_si follows", core_si, 1'b1);
    core_so = 1'b1; #1;
    chk("R10", "so_data", so_data, 1'b1);
    sclk_pin = 1'b0; si_pin = 1'b0; settle();
    chk("R10", "core_sclk low", core_sclk, 1'b0);
  endtask

  task automatic t_enter_low;
    si_pin = 1'b1; settle();
    hold_n_pin = 1'b0; settle();
    chk("R2", "hold after fall, clk low", hold_active, 1'b1);
    chk("R8", "so_oe off in pause", so_oe, 1'b0);
    for (int i = 0; i < 4; i++) begin
      sclk_pin = ~sclk_pin; si_pin = ~si_pin; settle(3);
      chk("R7", "core_sclk held low", core_sclk, 1'b0);
      chk("R7", "core_si frozen", core_si, 1'b1);
    end
    hold_n_pin = 1'b1; settle();
    chk("R5", "release with clk low", hold_active, 1'b0);
    chk("R8", "so_oe restored on", so_oe, 1'b1);
  endtask

  task automatic t_deferred;
    sclk_pin = 1'b1; settle();
    hold_n_pin = 1'b0; settle();
    chk("R3", "no hold while clk high", hold_active, 1'b0);
    sclk_pin = 1'b0; settle();
    chk("R3", "hold once clk low", hold_active, 1'b1);
    sclk_pin = 1'b1; settle();
    hold_n_pin = 1'b1; settle();
    chk("R6", "still paused, clk high", hold_active, 1'b1);
    chk("R6", "core_sclk still low", core_sclk, 1'b0);
    sclk_pin = 1'b0; settle();
    chk("R6", "released once clk low", hold_active, 1'b0);
  endtask

  task automatic t_cancel;
    sclk_pin = 1'b1; settle();
    hold_n_pin = 1'b0; settle();
    hold_n_pin = 1'b1; settle();
    sclk_pin = 1'b0; settle();
    chk("R11", "armed pause dropped", hold_active, 1'b0);
  endtask

  task automatic t_deselected_fall;
    cs_n_pin = 1'b1; settle();
    hold_n_pin = 1'b0; settle();
    chk("R4", "no hold while deselected", hold_active, 1'b0);
    cs_n_pin = 1'b0; settle();
    chk("R4", "no hold after select", hold_active, 1'b0);
    chk("R10", "so_oe on (not paused)", so_oe, 1'b1);
    hold_n_pin = 1'b1; settle();
  endtask

  task automatic t_restore_off;
    core_so_oe = 1'b0;
    hold_n_pin = 1'b0; settle();
    chk("R2", "hold entered", hold_active, 1'b1);
    hold_n_pin = 1'b1; settle();
    chk("R8", "so_oe restored off", so_oe, 1'b0);
    core_so_oe = 1'b1; #1;
    chk("R8", "so_oe follows core again", so_oe, 1'b1);
  endtask

  task automatic t_drop;
    int high_cnt;
    hold_n_pin = 1'b0; settle();
    chk("R9", "hold before drop", hold_active, 1'b1);
    cs_n_pin = 1'b1;
    high_cnt = 0;
    for (int i = 0; i < RST_LEN + 8; i++) begin
      @(negedge clk);
      if (core_rst) high_cnt++;
    end
    checks++;
    if (high_cnt != RST_LEN) begin
      fails++;
      $display("FAIL R9 core_rst width actual=%0d expected=%0d", high_cnt, RST_LEN);
    end
    chk("R9", "hold cleared", hold_active, 1'b0);
    chk("R9", "core_rst ended", core_rst, 1'b0);
    hold_n_pin = 1'b1; cs_n_pin = 1'b0; settle();
    chk("R9", "clean restart, no hold", hold_active, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    t_reset();
    t_pass();
    t_enter_low();
    t_deferred();
    t_cancel();
    t_deselected_fall();
    t_restore_off();
    t_drop();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule